// File: doc/BRIEF.md
# Stream-identifier span filter for event counters

This block sits in front of a bank of performance counters and decides, for every monitored event, which counters may count it. Each event arrives as a one-cycle strobe carrying an event type and a stream identifier. Every counter owns a match value, a span flag and an event selector. A counter is qualified when the event type equals its selector and the stream identifier passes its stream filter.

With the span flag clear, the stream filter demands exact equality. With the span flag set, the match value encodes its own don't-care width. The lowest zero bit of the match value, together with every one bit below it, marks low-order identifier bits that are ignored. All higher bits must still agree. A match value of all ones with span set therefore accepts every identifier. A global-mode input makes counter 0's match value and span flag apply to every counter, while each counter keeps its own selector.

The qualifier vector is registered, so each counter sees its increment exactly one cycle after the event strobe. Configuration is written one register at a time through a small write port. Counter storage, interrupts and the bus interface belong to neighbouring blocks.

Top module: `sid_span_filter`

## Requirements
- R1: After reset every qualifier bit is 0, every match value is all ones, every span flag is 1 and every selector is 0, so an event of type 0 qualifies all counters.
- R2: In a cycle with no event strobe, the qualifier vector in the following cycle is all zero.
- R3: The qualifier for an event appears in the cycle directly after the strobe and lasts one cycle.
- R4: A counter is never qualified for an event whose type differs from its selector.
- R5: With span clear, a counter is qualified only if the stream identifier equals its match value exactly.
- R6: With span set, if the lowest zero of the match value is at bit Y-1, the low Y identifier bits are ignored and bits Y and upward must equal the match value.
- R7: A span-mode match value of 0x42 accepts identifiers 0x42 and 0x43 and rejects 0x40 and 0x44.
- R8: A span-mode match value of all ones accepts every identifier.
- R9: A write with select 0 loads the match value of the addressed counter from the write data. A write with select 1 loads the type register: bits 15:0 are the selector, bit 29 is the span flag, and all other bits are ignored. Written settings apply from the first event after the write's clock edge, so an event in the same cycle as a write uses the old settings.
- R10: With global mode high, every counter's stream filter uses counter 0's match value and span flag, combined with its own selector.
- R11: With global mode high, the match values and span flags of counters other than 0 have no effect on the qualifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| global_mode | input | 1 | 1: counter 0's stream filter applies to all counters |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 1 | 0: match value, 1: type register (selector and span) |
| cfg_wr_idx | input | IDX_W (2) | Counter addressed by the write |
| cfg_wr_data | input | 32 | Write data |
| ev_valid | input | 1 | Event strobe |
| ev_type | input | EVT_W (16) | Event type of the strobed event |
| ev_sid | input | SID_W (32) | Stream identifier of the strobed event |
| cnt_qual | output | NUM_CTR (4) | Per-counter count qualifier, one cycle after the strobe |

## Verification
The bench builds the block with four counters, 32-bit stream identifiers and 16-bit event types. Four counters are enough to hold an exact filter, two different span widths and a match-all filter at the same time, so one event exercises every filter kind in parallel. The full 32-bit identifier width covers the all-ones match value and a span that reaches the top bit. In global mode the other three counters can be set to values that would reject an event, which shows that their settings have no effect.

// File: rtl/sidf_pkg.sv
package sidf_pkg;
    localparam int REG_W    = 32;
    localparam int SPAN_POS = 29;

    typedef enum logic {
        WSEL_MATCH = 1'b0,
        WSEL_TYPE  = 1'b1
    } wsel_e;
endpackage

// File: rtl/sidf_cfg_bank.sv
module sidf_cfg_bank
    import sidf_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int SID_W   = 32,
    parameter int EVT_W   = 16,
    parameter int IDX_W   = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic                              wr_sel,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [REG_W-1:0]                  wr_data,
    output logic [NUM_CTR-1:0][SID_W-1:0]     match_o,
    output logic [NUM_CTR-1:0]                span_o,
    output logic [NUM_CTR-1:0][EVT_W-1:0]     evsel_o
);
    typedef struct packed {
        logic [NUM_CTR-1:0][SID_W-1:0] match;
        logic [NUM_CTR-1:0]            span;
        logic [NUM_CTR-1:0][EVT_W-1:0] evsel;
    } bank_t;

    bank_t st_d, st_q;
    wsel_e sel;

    assign sel = wsel_e'(wr_sel);

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (wr_en && (int'(wr_idx) == i)) begin
                if (sel == WSEL_MATCH) begin
                    st_d.match[i] = wr_data[SID_W-1:0];
                end else begin
                    st_d.evsel[i] = wr_data[EVT_W-1:0];
                    st_d.span[i]  = wr_data[SPAN_POS];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.match <= '1;
            st_q.span  <= '1;
            st_q.evsel <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign match_o = st_q.match;
    assign span_o  = st_q.span;
    assign evsel_o = st_q.evsel;

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_chk
        p_match_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_sel && int'(wr_idx) == g)
            |=> (match_o[g] == $past(wr_data[SID_W-1:0])));
        p_type_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel && int'(wr_idx) == g)
            |=> (span_o[g] == $past(wr_data[SPAN_POS])
                 && evsel_o[g] == $past(wr_data[EVT_W-1:0])));
    end
endmodule

// File: rtl/sidf_span_match.sv
module sidf_span_match #(
    parameter int SID_W = 32
) (
    input  logic [SID_W-1:0] match_val,
    input  logic             span,
    input  logic [SID_W-1:0] sid,
    output logic             hit
);
    logic [SID_W-1:0] care_n;
    logic [SID_W-1:0] diff;

    always_comb begin
        // ones at the lowest zero of match_val and every bit below it;
        // all ones when match_val itself is all ones
        care_n = match_val ^ (match_val + 1'b1);
        diff   = sid ^ match_val;
        if (span) hit = ((diff & ~care_n) == '0);
        else      hit = (diff == '0);
    end
endmodule

// File: rtl/sid_span_filter.sv
module sid_span_filter
    import sidf_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int SID_W   = 32,
    parameter int EVT_W   = 16,
    localparam int IDX_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               global_mode,
    input  logic               cfg_wr_en,
    input  logic               cfg_wr_sel,
    input  logic [IDX_W-1:0]   cfg_wr_idx,
    input  logic [31:0]        cfg_wr_data,
    input  logic               ev_valid,
    input  logic [EVT_W-1:0]   ev_type,
    input  logic [SID_W-1:0]   ev_sid,
    output logic [NUM_CTR-1:0] cnt_qual
);
    logic [NUM_CTR-1:0][SID_W-1:0] match_r;
    logic [NUM_CTR-1:0]            span_r;
    logic [NUM_CTR-1:0][EVT_W-1:0] evsel_r;
    logic [NUM_CTR-1:0][SID_W-1:0] eff_match;
    logic [NUM_CTR-1:0]            eff_span;
    logic [NUM_CTR-1:0]            sid_hit;

    typedef struct packed {
        logic [NUM_CTR-1:0] qual;
    } qual_t;

    qual_t st_d, st_q;

    sidf_cfg_bank #(
        .NUM_CTR(NUM_CTR), .SID_W(SID_W), .EVT_W(EVT_W), .IDX_W(IDX_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .wr_idx  (cfg_wr_idx),
        .wr_data (cfg_wr_data),
        .match_o (match_r),
        .span_o  (span_r),
        .evsel_o (evsel_r)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        assign eff_match[g] = global_mode ? match_r[0] : match_r[g];
        assign eff_span[g]  = global_mode ? span_r[0]  : span_r[g];

        sidf_span_match #(.SID_W(SID_W)) u_match (
            .match_val (eff_match[g]),
            .span      (eff_span[g]),
            .sid       (ev_sid),
            .hit       (sid_hit[g])
        );

        p_type_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_valid && ev_type != evsel_r[g]) |=> !cnt_qual[g]);
        p_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_valid && !eff_span[g] && ev_sid != eff_match[g]) |=> !cnt_qual[g]);
        p_match_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_valid && eff_span[g] && (&eff_match[g]) && ev_type == evsel_r[g])
            |=> cnt_qual[g]);
        p_global_same_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (global_mode && ev_valid && ev_type == evsel_r[g] && ev_type == evsel_r[0])
            |=> (cnt_qual[g] == cnt_qual[0]));
    end

    always_comb begin
        st_d = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            st_d.qual[i] = ev_valid && (ev_type == evsel_r[i]) && sid_hit[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_qual = st_q.qual;

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> (cnt_qual == '0));
endmodule

// File: tb/sid_span_filter_tb.sv
module sid_span_filter_tb;
    localparam int NC = 4;
    localparam int SW = 32;
    localparam int EW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          global_mode = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic          cfg_wr_sel = 1'b0;
    logic [1:0]    cfg_wr_idx = '0;
    logic [31:0]   cfg_wr_data = '0;
    logic          ev_valid = 1'b0;
    logic [EW-1:0] ev_type = '0;
    logic [SW-1:0] ev_sid = '0;
    logic [NC-1:0] cnt_qual;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [31:0]   m_match [NC];
    bit            m_span  [NC];
    logic [EW-1:0] m_sel   [NC];
    logic [NC-1:0] exp_q = '0;
    string         exp_tag = "R1";

    always #4 clk = ~clk;

    sid_span_filter #(.NUM_CTR(NC), .SID_W(SW), .EVT_W(EW)) u_dut (
        .clk(clk), .rst_n(rst_n), .global_mode(global_mode),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_idx(cfg_wr_idx),
        .cfg_wr_data(cfg_wr_data), .ev_valid(ev_valid), .ev_type(ev_type),
        .ev_sid(ev_sid), .cnt_qual(cnt_qual)
    );

    function automatic bit ref_hit(logic [31:0] mv, bit sp, logic [31:0] sid);
        int y;
        if (!sp) return sid == mv;
        y = 32;
        for (int b = 0; b < 32; b++) begin
            if (!mv[b]) begin
                y = b + 1;
                break;
            end
        end
        for (int b = y; b < 32; b++)
            if (sid[b] != mv[b]) return 0;
        return 1;
    endfunction

    task automatic check_now();
        checks++;
        if (cnt_qual !== exp_q) begin
            errors++;
            $display("FAIL %s: cnt_qual=%b expected=%b", exp_tag, cnt_qual, exp_q);
        end
    endtask

    // one clock: check the previous cycle's outcome, drive new inputs, predict
    task automatic step(bit wr, bit sel, int idx, logic [31:0] data, bit gm,
                        bit v, logic [EW-1:0] t, logic [31:0] sid, string tag);
        @(negedge clk);
        check_now();
        cfg_wr_en = wr; cfg_wr_sel = sel; cfg_wr_idx = idx[1:0];
        cfg_wr_data = data; global_mode = gm;
        ev_valid = v; ev_type = t; ev_sid = sid;
        for (int i = 0; i < NC; i++) begin
            logic [31:0] mv;
            bit sp;
            mv = gm ? m_match[0] : m_match[i];
            sp = gm ? m_span[0]  : m_span[i];
            exp_q[i] = v && (t == m_sel[i]) && ref_hit(mv, sp, sid);
        end
        exp_tag = tag;
        if (wr) begin
            if (!sel) m_match[idx] = data;
            else begin
                m_sel[idx]  = data[EW-1:0];
                m_span[idx] = data[29];
            end
        end
    endtask

    task automatic ev(bit gm, logic [EW-1:0] t, logic [31:0] sid, string tag);
        step(0, 0, 0, '0, gm, 1, t, sid, tag);
    endtask

    task automatic wr_cfg(bit sel, int idx, logic [31:0] data, string tag);
        step(1, sel, idx, data, 0, 0, '0, '0, tag);
    endtask

    initial begin
        for (int i = 0; i < NC; i++) begin
            m_match[i] = '1; m_span[i] = 1; m_sel[i] = '0;
        end
        repeat (3) begin
            @(negedge clk);
            check_now();                           // R1 reset state
        end
        rst_n = 1'b1;
        ev(0, 16'h0, 32'h1234_5678, "R1");         // defaults accept all
        ev(0, 16'h0, 32'h0, "R8");
        ev(0, 16'h1, 32'h0, "R4");                 // type mismatch
        step(0, 0, 0, '0, 0, 0, 16'h0, 32'h0, "R2");
        step(0, 0, 0, '0, 0, 0, 16'h0, 32'h0, "R3");

        // counter 0: exact 0x1234, counter 1: span 0x42,
        // counter 2: span 0x0F (low 5 bits ignored), counter 3: match all
        wr_cfg(0, 0, 32'h0000_1234, "R9");
        wr_cfg(1, 0, 32'hDEAD_0001, "R9");         // bit29=0, junk above ignored
        wr_cfg(0, 1, 32'h0000_0042, "R9");
        wr_cfg(1, 1, 32'h2000_0001, "R9");
        wr_cfg(0, 2, 32'h0000_000F, "R9");
        wr_cfg(1, 2, 32'h2000_0002, "R9");
        wr_cfg(1, 3, 32'h2000_0001, "R9");

        ev(0, 16'h1, 32'h0000_1234, "R5");
        ev(0, 16'h1, 32'h0000_1235, "R5");
        ev(0, 16'h1, 32'h0000_0042, "R7");
        ev(0, 16'h1, 32'h0000_0043, "R7");
        ev(0, 16'h1, 32'h0000_0040, "R7");
        ev(0, 16'h1, 32'h0000_0044, "R7");
        ev(0, 16'h2, 32'h0000_001F, "R6");
        ev(0, 16'h2, 32'h0000_0000, "R6");
        ev(0, 16'h2, 32'h0000_0020, "R6");
        ev(0, 16'h2, 32'h8000_0005, "R6");
        ev(0, 16'h1, 32'hFFFF_FFFF, "R8");
        step(0, 0, 0, '0, 0, 0, 16'h1, 32'h0000_1234, "R2");

        // span reaching the top bit: 0x7FFF_FFFF ignores all 32 bits
        wr_cfg(0, 2, 32'h7FFF_FFFF, "R9");
        ev(0, 16'h2, 32'hA5A5_A5A5, "R6");

        // write and event in the same cycle: old settings apply
        step(1, 0, 0, 32'h0000_0077, 0, 1, 16'h1, 32'h0000_1234, "R9");
        ev(0, 16'h1, 32'h0000_1234, "R9");
        ev(0, 16'h1, 32'h0000_0077, "R9");

        for (int k = 0; k < 200; k++)
            ev(0, EW'($urandom_range(0, 2)),
               (k % 2) ? $urandom : (32'h40 | $urandom_range(0, 7)), "R6");

        // global mode: counter 0 span 0x42 drives all counters
        wr_cfg(0, 0, 32'h0000_0042, "R10");
        wr_cfg(1, 0, 32'h2000_0001, "R10");
        wr_cfg(1, 2, 32'h0000_0001, "R11");        // exact, match 0x7FFF_FFFF
        wr_cfg(0, 1, 32'h0000_0999, "R11");
        wr_cfg(1, 1, 32'h0000_0001, "R11");
        ev(1, 16'h1, 32'h0000_0042, "R10");
        ev(1, 16'h1, 32'h0000_0043, "R11");
        ev(1, 16'h1, 32'h0000_0999, "R11");
        ev(1, 16'h1, 32'h0000_0044, "R10");
        ev(1, 16'h0, 32'h0000_0042, "R4");
        for (int k = 0; k < 100; k++)
            ev(1, 16'h1, 32'h40 | $urandom_range(0, 7), "R10");
        step(0, 0, 0, '0, 0, 0, 16'h0, 32'h0, "R2");
        step(0, 0, 0, '0, 0, 0, 16'h0, 32'h0, "R2");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule